// File: doc/BRIEF.md
# Two-Key Region Write Unlock Controller

This block is a small register peripheral that keeps two memory regions, program memory and data memory, write protected. Each region has its own key register. Software opens a region by writing two 8-bit keys to that register, one after the other. The block compares each written value with a fixed constant and never stores it. After the second correct key, the region's unlock bit in a shared status register goes high. The matching write-enable output to the memory controller follows that bit directly.

The two regions expect the same two constants but in opposite order. They also handle a bad first key differently. On the program register, a bad first key shuts the register until the next reset. On the data register, software may start the sequence again. A bad second key shuts either register until reset.

Software relocks a region by writing a zero to its status bit. A relocked region returns to its idle key state and accepts a fresh two-key sequence. The bus port is a single-cycle write strobe with an address and write data. Read data follows the address combinationally. The asynchronous reset input is released through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `keyed_write_guard`

## Requirements
- R1: After reset, both write-enable outputs are low and the status register (offset 0x2) reads 0x00.
- R2: Writing 0x56 and then 0xAE to the program key register (offset 0x0) sets status bit 0. `prog_wr_en` rises on the clock edge that accepts the second key.
- R3: Writing 0xAE and then 0x56 to the data key register (offset 0x1) sets status bit 1. `data_wr_en` rises on the clock edge that accepts the second key.
- R4: A first write other than 0x56 to the program key register locks it until reset. Any later sequence to that register, correct or not, leaves status bit 0 at 0.
- R5: A first write other than 0xAE to the data key register leaves it in its idle state. A correct two-key sequence written afterwards still sets status bit 1.
- R6: For either region, a correct first key followed by a wrong second key leaves the region protected until reset. Any later writes to that key register are ignored.
- R7: A status write with 0 in a region's bit (bit 0 for program, bit 1 for data) clears that bit and drops its write-enable on the next edge. A status write with 1 in a bit never sets it.
- R8: After a relock through R7, a fresh correct two-key sequence unlocks the region again. A region in lockout becomes unlockable only after reset.
- R9: Reads of either key register return 0x00. Reads of the status register return the two unlock bits, and each write-enable output always equals its status bit.
- R10: The two regions are independent. Writes to one key register never change the other region's unlock bit or lockout. Writing the right values in the wrong order fails like any wrong key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_addr | input | ADDR_W | Register offset for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| prog_wr_en | output | 1 | Program memory write enable (status bit 0) |
| data_wr_en | output | 1 | Data memory write enable (status bit 1) |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 4-bit offset, keys 0x56 and 0xAE, and the status bits at positions 0 and 1. This makes every branch of both key machines reachable through a few register writes. These branches are the retry path, the two lockout paths, the relock-and-reopen loop, and the swapped-order failure. The bench applies reset between scenarios, because lockout can only be left through reset.

// File: rtl/wguard_pkg.sv
package wguard_pkg;

  // Key acceptance progress for one region.
  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,  // waiting for the first key
    KS_HALF = 2'd1,  // first key accepted, waiting for the second
    KS_OPEN = 2'd2,  // region writable
    KS_DEAD = 2'd3   // terminal lockout until reset
  } key_state_e;

endpackage

// File: rtl/wguard_rst_sync.sv
module wguard_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wguard_decode.sv
module wguard_decode #(
  parameter int          ADDR_W   = 4,
  parameter int          DATA_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_PKEY = 4'h0,
  parameter logic [ADDR_W-1:0] OFS_DKEY = 4'h1,
  parameter logic [ADDR_W-1:0] OFS_STAT = 4'h2,
  parameter int          PROG_BIT = 0,
  parameter int          DATA_BIT = 1
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [1:0]        key_wr,
  output logic [1:0]        relock
);
  logic stat_wr;

  always_comb begin
    stat_wr   = bus_wr && (bus_addr == OFS_STAT);
    key_wr[0] = bus_wr && (bus_addr == OFS_PKEY);
    key_wr[1] = bus_wr && (bus_addr == OFS_DKEY);
    relock[0] = stat_wr && !bus_wdata[PROG_BIT];
    relock[1] = stat_wr && !bus_wdata[DATA_BIT];
  end
endmodule

// File: rtl/wguard_key_fsm.sv
module wguard_key_fsm
  import wguard_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-1:0] FIRST_KEY   = 8'h56,
  parameter logic [DATA_W-1:0] SECOND_KEY  = 8'hAE,
  parameter bit                RETRY_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  input  logic              relock,
  output logic              unlocked
);
  key_state_e state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KS_IDLE: if (key_wr) begin
        if (key_val == FIRST_KEY) state_d = KS_HALF;
        else if (!RETRY_FIRST)    state_d = KS_DEAD;
      end
      KS_HALF: if (key_wr) begin
        state_d = (key_val == SECOND_KEY) ? KS_OPEN : KS_DEAD;
      end
      KS_OPEN: if (relock) state_d = KS_IDLE;
      KS_DEAD: state_d = KS_DEAD;
      default: state_d = KS_DEAD;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= KS_IDLE;
    else if (state_en) state_q <= state_d;
  end

  assign unlocked = (state_q == KS_OPEN);
endmodule

// File: rtl/keyed_write_guard.sv
module keyed_write_guard #(
  parameter int                ADDR_W     = 4,
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] KEY_LO     = 8'h56,
  parameter logic [DATA_W-1:0] KEY_HI     = 8'hAE,
  parameter logic [ADDR_W-1:0] OFS_PKEY   = 4'h0,
  parameter logic [ADDR_W-1:0] OFS_DKEY   = 4'h1,
  parameter logic [ADDR_W-1:0] OFS_STAT   = 4'h2,
  parameter int                PROG_BIT   = 0,
  parameter int                DATA_BIT   = 1,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              prog_wr_en,
  output logic              data_wr_en
);
  localparam int NREG = 2;
  // Region 0 = program memory, region 1 = data memory.
  localparam logic [NREG*DATA_W-1:0] FIRST_TBL  = {KEY_HI, KEY_LO};
  localparam logic [NREG*DATA_W-1:0] SECOND_TBL = {KEY_LO, KEY_HI};
  localparam logic [NREG-1:0]        RETRY_TBL  = 2'b10;

  logic            core_rst_n;
  logic [NREG-1:0] key_wr;
  logic [NREG-1:0] relock;
  logic [NREG-1:0] unlocked;

  wguard_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  wguard_decode #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .OFS_PKEY (OFS_PKEY),
    .OFS_DKEY (OFS_DKEY),
    .OFS_STAT (OFS_STAT),
    .PROG_BIT (PROG_BIT),
    .DATA_BIT (DATA_BIT)
  ) u_dec (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .key_wr    (key_wr),
    .relock    (relock)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_region
    wguard_key_fsm #(
      .DATA_W      (DATA_W),
      .FIRST_KEY   (FIRST_TBL[g*DATA_W +: DATA_W]),
      .SECOND_KEY  (SECOND_TBL[g*DATA_W +: DATA_W]),
      .RETRY_FIRST (RETRY_TBL[g])
    ) u_fsm (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .key_wr   (key_wr[g]),
      .key_val  (bus_wdata),
      .relock   (relock[g]),
      .unlocked (unlocked[g])
    );
  end

  assign prog_wr_en = unlocked[0];
  assign data_wr_en = unlocked[1];

  // Key registers hold nothing, so they read as zero.
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_STAT) begin
      bus_rdata[PROG_BIT] = unlocked[0];
      bus_rdata[DATA_BIT] = unlocked[1];
    end
  end
endmodule

// File: rtl/keyed_write_guard_chk.sv
module keyed_write_guard_chk #(
  parameter int                ADDR_W   = 4,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] KEY_LO   = 8'h56,
  parameter logic [DATA_W-1:0] KEY_HI   = 8'hAE,
  parameter logic [ADDR_W-1:0] OFS_PKEY = 4'h0,
  parameter logic [ADDR_W-1:0] OFS_DKEY = 4'h1,
  parameter logic [ADDR_W-1:0] OFS_STAT = 4'h2,
  parameter int                PROG_BIT = 0,
  parameter int                DATA_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              prog_wr_en,
  input logic              data_wr_en
);
  // R2: program enable only rises from an accepted second program key
  p_prog_rise_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_wr_en) |-> $past(bus_wr && bus_addr == OFS_PKEY && bus_wdata == KEY_HI));

  // R3: data enable only rises from an accepted second data key
  p_data_rise_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_wr_en) |-> $past(bus_wr && bus_addr == OFS_DKEY && bus_wdata == KEY_LO));

  // R7: clearing a status bit drops the enable on the next edge
  p_prog_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_STAT && !bus_wdata[PROG_BIT]) |=> !prog_wr_en);

  p_data_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_STAT && !bus_wdata[DATA_BIT]) |=> !data_wr_en);

  // R9: key reads are zero; status read mirrors the enables
  p_key_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_PKEY || bus_addr == OFS_DKEY) |-> bus_rdata == '0);

  p_status_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_STAT) |->
      (bus_rdata[PROG_BIT] == prog_wr_en && bus_rdata[DATA_BIT] == data_wr_en));

  // R10: a data key write never changes the program enable, and vice versa
  p_prog_indep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DKEY) |=> $stable(prog_wr_en));

  p_data_indep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_PKEY) |=> $stable(data_wr_en));
endmodule

bind keyed_write_guard keyed_write_guard_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .KEY_LO   (KEY_LO),
  .KEY_HI   (KEY_HI),
  .OFS_PKEY (OFS_PKEY),
  .OFS_DKEY (OFS_DKEY),
  .OFS_STAT (OFS_STAT),
  .PROG_BIT (PROG_BIT),
  .DATA_BIT (DATA_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .prog_wr_en (prog_wr_en),
  .data_wr_en (data_wr_en)
);

// File: tb/keyed_write_guard_test.sv
`timescale 1ns/1ps
module keyed_write_guard_test;
  localparam logic [3:0] A_PK = 4'h0;
  localparam logic [3:0] A_DK = 4'h1;
  localparam logic [3:0] A_ST = 4'h2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       prog_wr_en;
  logic       data_wr_en;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  keyed_write_guard uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .prog_wr_en (prog_wr_en),
    .data_wr_en (data_wr_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = A_ST; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Drive on a falling edge, let one rising edge take it, return on the next falling edge.
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_status(output logic [7:0] v);
    bus_addr = A_ST;
    #0.5 v = bus_rdata;
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    do_reset();
    rd_status(v);
    check("R1 status", v, 8'h00);
    check("R1 enables", {6'b0, data_wr_en, prog_wr_en}, 8'h00);
  endtask

  task automatic t_prog_unlock();
    logic [7:0] v;
    do_reset();
    wr(A_PK, 8'h56);
    check("R2 after first key", {7'b0, prog_wr_en}, 8'h00);
    wr(A_PK, 8'hAE);
    check("R2 prog_wr_en", {7'b0, prog_wr_en}, 8'h01);
    rd_status(v);
    check("R2 status", v, 8'h01);
    check("R10 data stays locked", {7'b0, data_wr_en}, 8'h00);
    bus_addr = A_PK; #0.5;
    check("R9 prog key read", bus_rdata, 8'h00);
    bus_addr = A_DK; #0.5;
    check("R9 data key read", bus_rdata, 8'h00);
  endtask

  task automatic t_data_unlock();
    logic [7:0] v;
    do_reset();
    wr(A_DK, 8'hAE);
    wr(A_DK, 8'h56);
    check("R3 data_wr_en", {7'b0, data_wr_en}, 8'h01);
    rd_status(v);
    check("R3 status", v, 8'h02);
    check("R10 prog stays locked", {7'b0, prog_wr_en}, 8'h00);
  endtask

  task automatic t_prog_bad_first();
    do_reset();
    wr(A_PK, 8'h57);
    wr(A_PK, 8'h56);
    wr(A_PK, 8'hAE);
    check("R4 prog lockout", {7'b0, prog_wr_en}, 8'h00);
    wr(A_DK, 8'hAE);
    wr(A_DK, 8'h56);
    check("R10 data unaffected by prog lockout", {7'b0, data_wr_en}, 8'h01);
  endtask

  task automatic t_data_retry();
    do_reset();
    wr(A_DK, 8'h00);
    wr(A_DK, 8'h56);
    check("R5 no unlock yet", {7'b0, data_wr_en}, 8'h00);
    wr(A_DK, 8'hAE);
    wr(A_DK, 8'h56);
    check("R5 unlock after retry", {7'b0, data_wr_en}, 8'h01);
  endtask

  task automatic t_bad_second();
    do_reset();
    wr(A_PK, 8'h56);
    wr(A_PK, 8'h00);
    wr(A_PK, 8'h56);
    wr(A_PK, 8'hAE);
    check("R6 prog bad second", {7'b0, prog_wr_en}, 8'h00);
    wr(A_DK, 8'hAE);
    wr(A_DK, 8'hAE);
    wr(A_DK, 8'hAE);
    wr(A_DK, 8'h56);
    check("R6 data bad second", {7'b0, data_wr_en}, 8'h00);
    // reset lifts the lockout
    do_reset();
    wr(A_PK, 8'h56);
    wr(A_PK, 8'hAE);
    check("R8 unlock after reset", {7'b0, prog_wr_en}, 8'h01);
  endtask

  task automatic t_relock();
    logic [7:0] v;
    do_reset();
    wr(A_ST, 8'hFF);
    check("R7 status write cannot set", {6'b0, data_wr_en, prog_wr_en}, 8'h00);
    wr(A_PK, 8'h56); wr(A_PK, 8'hAE);
    wr(A_DK, 8'hAE); wr(A_DK, 8'h56);
    wr(A_ST, 8'h02);
    rd_status(v);
    check("R7 clear prog only", v, 8'h02);
    wr(A_ST, 8'h00);
    rd_status(v);
    check("R7 clear data", v, 8'h00);
    wr(A_PK, 8'h56); wr(A_PK, 8'hAE);
    check("R8 prog reopens", {7'b0, prog_wr_en}, 8'h01);
    wr(A_DK, 8'hAE); wr(A_DK, 8'h56);
    check("R8 data reopens", {7'b0, data_wr_en}, 8'h01);
  endtask

  task automatic t_swapped_order();
    do_reset();
    wr(A_PK, 8'hAE);
    wr(A_PK, 8'h56);
    check("R10 prog swapped order fails", {7'b0, prog_wr_en}, 8'h00);
    wr(A_DK, 8'h56);
    wr(A_DK, 8'hAE);
    check("R10 data swapped order fails", {7'b0, data_wr_en}, 8'h00);
  endtask

  initial begin : watchdog
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = A_ST; bus_wdata = '0;
    t_reset_state();
    t_prog_unlock();
    t_data_unlock();
    t_prog_bad_first();
    t_data_retry();
    t_bad_second();
    t_relock();
    t_swapped_order();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule